// File: doc/BRIEF.md
# Multi-Source Reset Pulse Generator

This block turns a collection of reset requests from a system supervisor into one stretched, active-low pulse on a shared open-drain reset line. It raises requests of its own from three sources. It issues a power-on pulse once the main supply is first reported good. It detects falling edges on the sensed reset line that something outside the chip has pulled low. It also accepts any number of request inputs from the supervisor, such as low supply, overcurrent, supply short, flash entry or exit, wake-up, watchdog failure, illegal mode code and interrupt timeout. Every accepted event holds the line low for at least a short or a long interval. A length-control bit chooses between the two intervals. Software writes that bit, and the block forces it to the long setting while the controller is in a restart or fail-safe mode.

The block stores a code for the source of the most recent reset, so software can tell the causes apart. Software clears that code with a read-clear strobe. When an external pull-down starts a reset, the block watches the line, and it raises a sticky fail-safe request if the line is not released within a timeout. The open-drain pin is split into a sensed input and a drive-low output. All timing is counted in clock cycles, using a cycles-per-millisecond parameter.

Top module: `rst_pulse_gen`

## Requirements
- R1: After reset, the outputs are line_drive_low=0, cause=0, long_len=0 and failsafe_req=0.
- R2: A one-cycle pulse on any bit of req holds line_drive_low high for exactly SHORT_MS*CLK_PER_MS cycles, starting in the cycle after the request, when long_len is 0 and force_long is 0.
- R3: Writing len_val=1 with len_we sets long_len, and later events then hold the line low for exactly LONG_MS*CLK_PER_MS cycles. Writing len_val=0 returns to the short length.
- R4: While force_long is high, long_len becomes 1 and a request in the same cycle gets the long length. The bit stays 1 after force_long falls, and a len_val=0 write in a cycle where force_long is high has no effect.
- R5: The first time supply_ok is seen high after reset, the block issues a single short pulse with cause code 1. Later toggles of supply_ok issue no pulse.
- R6: A falling edge on line_in that the block is not itself driving starts a pulse of the selected length and records cause code 2.
- R7: The block's own drive of the line never counts as an external edge. A self-started pulse produces exactly one low period, and its cause code stays unchanged.
- R8: req[i] records cause code i+3. Priority among simultaneous events is power-on, then external edge, then req[0] up to req[N_REQ-1].
- R9: An event that arrives during an active pulse restarts the full low time from that cycle and replaces the cause code.
- R10: stat_clr sets cause to 0 on the next cycle. If an event arrives in the same cycle, the event's code is stored instead.
- R11: After an external edge, if line_in stays low for TMO_MS*CLK_PER_MS cycles, failsafe_req rises and stays high until rst_n. If the line is released earlier, failsafe_req stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low logic reset (first power connection) |
| supply_ok | input | 1 | Main supply reported present |
| req | input | N_REQ | Reset request strobes from the supervisor; bit 0 has the highest priority |
| len_we | input | 1 | Software write strobe for the length-control bit |
| len_val | input | 1 | Value written: 1 selects the long pulse |
| force_long | input | 1 | Restart or fail-safe mode active; forces the long setting |
| stat_clr | input | 1 | Read-clear strobe for the cause field |
| line_in | input | 1 | Sensed level of the reset line |
| line_drive_low | output | 1 | Open-drain enable: 1 pulls the reset line low |
| long_len | output | 1 | Current length-control bit |
| cause | output | CODE_W | Code of the last reset source (0 none, 1 power-on, 2 external, i+3 for req[i]) |
| failsafe_req | output | 1 | External hold-low timeout flag, sticky |

## Verification
The hardest case to reach is an event that lands in the middle of an active pulse. The bench counts low cycles at each falling clock edge, injects a second request four cycles into the pulse, and expects the total to be those four cycles plus one full pulse. A second hard case is the fail-safe timeout, which needs an external pull-down longer than the block's own drive. The bench models the wired line as the AND of both pull-downs and holds the outside one long enough to cross the timeout, after first releasing a short pull-down to show that no flag is raised.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
   localparam int CODE_NONE     = 0;
   localparam int CODE_POWER_ON = 1;
   localparam int CODE_EXTERNAL = 2;
   localparam int CODE_REQ_BASE = 3;

   function automatic int req_code(input int idx);
      return CODE_REQ_BASE + idx;
   endfunction
endpackage

// File: rtl/rpg_arbiter.sv
module rpg_arbiter
   import rpg_pkg::*;
#(
   parameter int N_REQ  = 10,
   parameter int CODE_W = 4
) (
   input  logic              por_req,
   input  logic              ext_req,
   input  logic [N_REQ-1:0]  req,
   output logic              trig,
   output logic              trig_short,
   output logic [CODE_W-1:0] code
);
   logic [N_REQ-1:0][CODE_W-1:0] req_codes;

   genvar gi;
   generate
      for (gi = 0; gi < N_REQ; gi++) begin : g_code
         assign req_codes[gi] = CODE_W'(req_code(gi));
      end
   endgenerate

   always_comb begin
      code = CODE_W'(CODE_NONE);
      for (int i = N_REQ - 1; i >= 0; i--) begin
         if (req[i]) code = req_codes[i];
      end
      if (ext_req) code = CODE_W'(CODE_EXTERNAL);
      if (por_req) code = CODE_W'(CODE_POWER_ON);
   end

   assign trig       = por_req | ext_req | (|req);
   assign trig_short = por_req;
endmodule

// File: rtl/rpg_sense.sv
module rpg_sense #(
   parameter int SYNC_STAGES = 2,
   parameter int TMO_CYC     = 40000,
   localparam int TCNT_W     = $clog2(TMO_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   input  logic self_drive,
   output logic ext_edge,
   output logic failsafe_req
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   line_s;
   logic                   line_d;
   logic                   armed;
   logic [TCNT_W-1:0]      tcnt;

   genvar gs;
   generate
      for (gs = 0; gs < SYNC_STAGES; gs++) begin : g_sync
         if (gs == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b1;
               else        sync_q[0] <= line_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[gs] <= 1'b1;
               else        sync_q[gs] <= sync_q[gs-1];
            end
         end
      end
   endgenerate

   assign line_s   = sync_q[SYNC_STAGES-1];
   assign ext_edge = line_d & ~line_s & ~self_drive;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_d <= 1'b1;
      else        line_d <= line_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed        <= 1'b0;
         tcnt         <= '0;
         failsafe_req <= 1'b0;
      end else begin
         if (ext_edge) begin
            armed <= 1'b1;
            tcnt  <= TCNT_W'(1);
         end else if (armed) begin
            if (line_s) begin
               armed <= 1'b0;
               tcnt  <= '0;
            end else if (tcnt >= TCNT_W'(TMO_CYC - 1)) begin
               failsafe_req <= 1'b1;
               armed        <= 1'b0;
            end else begin
               tcnt <= tcnt + TCNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/rpg_stretch.sv
module rpg_stretch #(
   parameter int SHORT_CYC = 1000,
   parameter int LONG_CYC  = 20000,
   localparam int CNT_W    = $clog2(LONG_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   input  logic trig_short,
   input  logic force_long,
   input  logic len_we,
   input  logic len_val,
   output logic long_len,
   output logic drive_low
);
   logic [CNT_W-1:0] cnt;
   logic             long_q;
   logic             use_long;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          long_q <= 1'b0;
      else if (force_long) long_q <= 1'b1;
      else if (len_we)     long_q <= len_val;
   end

   assign use_long = (long_q | force_long) & ~trig_short;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (trig)          cnt <= use_long ? CNT_W'(LONG_CYC) : CNT_W'(SHORT_CYC);
      else if (cnt != '0)     cnt <= cnt - CNT_W'(1);
   end

   assign drive_low = (cnt != '0);
   assign long_len  = long_q;
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen
   import rpg_pkg::*;
#(
   parameter int CLK_PER_MS  = 1000,
   parameter int SHORT_MS    = 1,
   parameter int LONG_MS     = 20,
   parameter int TMO_MS      = 40,
   parameter int N_REQ       = 10,
   parameter int SYNC_STAGES = 2,
   localparam int CODE_W     = $clog2(N_REQ + CODE_REQ_BASE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              supply_ok,
   input  logic [N_REQ-1:0]  req,
   input  logic              len_we,
   input  logic              len_val,
   input  logic              force_long,
   input  logic              stat_clr,
   input  logic              line_in,
   output logic              line_drive_low,
   output logic              long_len,
   output logic [CODE_W-1:0] cause,
   output logic              failsafe_req
);
   localparam int SHORT_CYC = SHORT_MS * CLK_PER_MS;
   localparam int LONG_CYC  = LONG_MS * CLK_PER_MS;
   localparam int TMO_CYC   = TMO_MS * CLK_PER_MS;

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (SHORT_CYC <= SYNC_STAGES + 1) begin : g_bad_short
         $error("short pulse must outlast the line synchronizer");
      end
      if (LONG_MS <= SHORT_MS) begin : g_bad_len
         $error("LONG_MS must exceed SHORT_MS");
      end
      if (TMO_MS <= LONG_MS) begin : g_bad_tmo
         $error("TMO_MS must exceed LONG_MS");
      end
      if (N_REQ < 1) begin : g_bad_nreq
         $error("N_REQ must be at least 1");
      end
   endgenerate

   logic              por_done;
   logic              por_req;
   logic              ext_edge;
   logic              trig;
   logic              trig_short;
   logic [CODE_W-1:0] trig_code;

   assign por_req = supply_ok & ~por_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       por_done <= 1'b0;
      else if (por_req) por_done <= 1'b1;
   end

   rpg_sense #(
      .SYNC_STAGES (SYNC_STAGES),
      .TMO_CYC     (TMO_CYC)
   ) u_sense (
      .clk          (clk),
      .rst_n        (rst_n),
      .line_in      (line_in),
      .self_drive   (line_drive_low),
      .ext_edge     (ext_edge),
      .failsafe_req (failsafe_req)
   );

   rpg_arbiter #(
      .N_REQ  (N_REQ),
      .CODE_W (CODE_W)
   ) u_arb (
      .por_req    (por_req),
      .ext_req    (ext_edge),
      .req        (req),
      .trig       (trig),
      .trig_short (trig_short),
      .code       (trig_code)
   );

   rpg_stretch #(
      .SHORT_CYC (SHORT_CYC),
      .LONG_CYC  (LONG_CYC)
   ) u_stretch (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig       (trig),
      .trig_short (trig_short),
      .force_long (force_long),
      .len_we     (len_we),
      .len_val    (len_val),
      .long_len   (long_len),
      .drive_low  (line_drive_low)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cause <= '0;
      else if (trig)     cause <= trig_code;
      else if (stat_clr) cause <= '0;
   end
endmodule

// File: rtl/rpg_chk.sv
module rpg_chk #(
   parameter int CODE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              trig,
   input logic              stat_clr,
   input logic              force_long,
   input logic              line_drive_low,
   input logic              long_len,
   input logic [CODE_W-1:0] cause,
   input logic              failsafe_req
);
   // R9
   trig_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> line_drive_low);

   // R10
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr && !trig) |=> (cause == '0));

   // R10
   cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_clr && !trig) |=> $stable(cause));

   // R11
   fs_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      failsafe_req |=> failsafe_req);

   // R4
   force_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_long |=> long_len);

   // R8
   cause_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_drive_low) |-> (cause != '0));
endmodule

bind rst_pulse_gen rpg_chk #(.CODE_W(CODE_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .trig           (trig),
   .stat_clr       (stat_clr),
   .force_long     (force_long),
   .line_drive_low (line_drive_low),
   .long_len       (long_len),
   .cause          (cause),
   .failsafe_req   (failsafe_req)
);

// File: tb/rst_pulse_gen_bench.sv
module rst_pulse_gen_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CPM    = 10;
   localparam int NREQ   = 10;
   localparam int SHORT  = 1 * CPM;
   localparam int LONG   = 20 * CPM;
   localparam int CW     = $clog2(NREQ + 3);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            supply_ok = 1'b0;
   logic [NREQ-1:0] req = '0;
   logic            len_we = 1'b0;
   logic            len_val = 1'b0;
   logic            force_long = 1'b0;
   logic            stat_clr = 1'b0;
   logic            ext_low = 1'b0;
   logic            line_in;
   logic            line_drive_low;
   logic            long_len;
   logic [CW-1:0]   cause;
   logic            failsafe_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   assign line_in = ~(line_drive_low | ext_low);

   always #(CLK_PERIOD / 2) clk = ~clk;

   rst_pulse_gen #(
      .CLK_PER_MS (CPM), .SHORT_MS (1), .LONG_MS (20), .TMO_MS (30),
      .N_REQ (NREQ), .SYNC_STAGES (2)
   ) u_rst_pulse_gen (
      .clk (clk), .rst_n (rst_n), .supply_ok (supply_ok), .req (req),
      .len_we (len_we), .len_val (len_val), .force_long (force_long),
      .stat_clr (stat_clr), .line_in (line_in),
      .line_drive_low (line_drive_low), .long_len (long_len),
      .cause (cause), .failsafe_req (failsafe_req)
   );

   task automatic check(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // count low cycles from the current negedge until the line is released
   task automatic measure(output int n);
      n = 0;
      while (line_drive_low && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic fire_req(input int idx);
      @(negedge clk);
      req[idx] = 1'b1;
      @(negedge clk);
      req[idx] = 1'b0;
   endtask

   task automatic count_window(input int len, output int n);
      n = 0;
      for (int i = 0; i < len; i++) begin
         if (line_drive_low) n++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset_state();
      check(line_drive_low == 0, "R1 drive", int'(line_drive_low), 0);
      check(cause == 0, "R1 cause", int'(cause), 0);
      check(long_len == 0, "R1 long_len", int'(long_len), 0);
      check(failsafe_req == 0, "R1 failsafe", int'(failsafe_req), 0);
   endtask

   task automatic t_power_on();
      int n;
      supply_ok = 1'b1;
      @(negedge clk);
      measure(n);
      check(n == SHORT, "R5 power-on length", n, SHORT);
      check(cause == 1, "R5 power-on code", int'(cause), 1);
      supply_ok = 1'b0;
      cyc(3);
      supply_ok = 1'b1;
      count_window(30, n);
      check(n == 0, "R5 single power-on pulse", n, 0);
   endtask

   task automatic t_short_pulse();
      int n;
      fire_req(3);
      measure(n);
      check(n == SHORT, "R2 short length", n, SHORT);
      check(cause == 6, "R8 code of req[3]", int'(cause), 6);
      count_window(20, n);
      check(n == 0, "R7 no self retrigger", n, 0);
      check(cause == 6, "R7 code kept after own pulse", int'(cause), 6);
   endtask

   task automatic t_length_bit();
      int n;
      @(negedge clk); len_we = 1'b1; len_val = 1'b1;
      @(negedge clk); len_we = 1'b0;
      check(long_len == 1, "R3 bit set", int'(long_len), 1);
      fire_req(0);
      measure(n);
      check(n == LONG, "R3 long length", n, LONG);
      @(negedge clk); len_we = 1'b1; len_val = 1'b0;
      @(negedge clk); len_we = 1'b0;
      fire_req(0);
      measure(n);
      check(n == SHORT, "R3 back to short", n, SHORT);
   endtask

   task automatic t_force_long();
      int n;
      @(negedge clk);
      force_long = 1'b1; req[5] = 1'b1; len_we = 1'b1; len_val = 1'b0;
      @(negedge clk);
      req[5] = 1'b0; len_we = 1'b0;
      measure(n);
      check(n == LONG, "R4 forced long same cycle", n, LONG);
      force_long = 1'b0;
      cyc(2);
      check(long_len == 1, "R4 bit sticky after force", int'(long_len), 1);
      @(negedge clk); len_we = 1'b1; len_val = 1'b0;
      @(negedge clk); len_we = 1'b0;
   endtask

   task automatic t_priority();
      @(negedge clk);
      req[2] = 1'b1; req[5] = 1'b1;
      @(negedge clk);
      req = '0;
      check(cause == 5, "R8 req[2] over req[5]", int'(cause), 5);
      @(negedge clk);
      req[0] = 1'b1; req[9] = 1'b1;
      @(negedge clk);
      req = '0;
      check(cause == 3, "R8 req[0] over req[9]", int'(cause), 3);
      cyc(SHORT + 5);
   endtask

   task automatic t_retrigger();
      int n = 0;
      fire_req(1);
      for (int k = 0; k < 4; k++) begin
         if (line_drive_low) n++;
         if (k == 3) req[7] = 1'b1;
         @(negedge clk);
      end
      req[7] = 1'b0;
      while (line_drive_low && n < 1000) begin
         n++;
         @(negedge clk);
      end
      check(n == 4 + SHORT, "R9 restart total low time", n, 4 + SHORT);
      check(cause == 10, "R9 newest code", int'(cause), 10);
   endtask

   task automatic t_clear();
      @(negedge clk); stat_clr = 1'b1;
      @(negedge clk); stat_clr = 1'b0;
      check(cause == 0, "R10 clear", int'(cause), 0);
      @(negedge clk); stat_clr = 1'b1; req[4] = 1'b1;
      @(negedge clk); stat_clr = 1'b0; req[4] = 1'b0;
      check(cause == 7, "R10 event wins over clear", int'(cause), 7);
      cyc(SHORT + 5);
   endtask

   task automatic t_external_short();
      int n;
      @(negedge clk); ext_low = 1'b1;
      cyc(3);
      ext_low = 1'b0;
      count_window(40, n);
      check(n == SHORT, "R6 external pulse length", n, SHORT);
      check(cause == 2, "R6 external code", int'(cause), 2);
      check(failsafe_req == 0, "R11 no flag on early release", int'(failsafe_req), 0);
   endtask

   task automatic t_external_hold();
      @(negedge clk); ext_low = 1'b1;
      cyc(250);
      check(failsafe_req == 0, "R11 flag not before timeout", int'(failsafe_req), 0);
      cyc(100);
      check(failsafe_req == 1, "R11 flag after timeout", int'(failsafe_req), 1);
      ext_low = 1'b0;
      cyc(20);
      check(failsafe_req == 1, "R11 flag sticky", int'(failsafe_req), 1);
   endtask

   initial begin
      cyc(4);
      t_reset_state();
      rst_n = 1'b1;
      cyc(5);
      check(line_drive_low == 0, "R5 no pulse before supply", int'(line_drive_low), 0);
      t_power_on();
      t_short_pulse();
      t_length_bit();
      t_force_long();
      t_priority();
      t_retrigger();
      t_clear();
      t_external_short();
      t_external_hold();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule